// File: doc/BRIEF.md
# Multichannel Conversion Result Parallel Readout Port

This block is the converter-side logic that hands eight latched 18-bit conversion results to a host over a 16-bit parallel bus. A conversion engine captures a fresh set of results with a one-cycle load pulse. The block then makes that set visible to the host when the busy indication falls. From then on, each falling edge of the combined select-and-read strobe presents one bus word. Each channel takes two words: the upper sixteen result bits first, then the two least significant bits. The channels are walked in ascending order.

The host may drive chip select and read separately. It may hold chip select low and pulse read, hold read low and pulse chip select, or tie the two together. The bus is modelled as a data word plus an output-enable flag; while the enable is low, the data word is forced to zero. A first-data flag marks the word that carries the upper bits of channel 1. All control inputs are sampled on the block clock. Bus changes therefore appear one clock after the strobes are seen.

Top module: `adc_par_readout`

## Requirements
- R1: `busOe` is 1 in the clock after a rising edge samples both `csN` and `rdN` low, and 0 in the clock after a rising edge samples either of them high. While `busOe` is 0, `busData` reads 0.
- R2: A new word is presented only when the sampled strobe pair goes from "not both low" to "both low". Holding both low, or pulling `rdN` low while `csN` is high, does not advance the word sequence.
- R3: Word 2k (k = 0..7) carries bits [17:2] of channel k+1's result on `busData[15:0]`.
- R4: Word 2k+1 carries bits [1:0] of channel k+1's result on `busData[1:0]`, with `busData[15:2]` driven as 0.
- R5: Sixteen successive strobes present words 0 through 15 in order, so channels 1 to 8 are read in ascending order and the 16th word is the two LSBs of channel 8.
- R6: A strobe after the 16th wraps back to word 0, the upper bits of channel 1.
- R7: A `loadStb` pulse captures `resIn` (channel c in bits [18c+17:18c], c = 0..7) into a staging store. Words read while `busy` is high still come from the previous result set, and the word sequence is not disturbed.
- R8: When `busy` falls (1 in one sampled clock, 0 in the next), the staged set becomes the readable set and the next strobe presents word 0.
- R9: `firstData` is 1 exactly while `busOe` is 1 and word 0 is on the bus, and 0 otherwise.
- R10: The three strobe styles advance by one word per pulse, with identical results: select and read pulsed together, select held low with read pulsed, and read held low with select pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Conversion in progress; its falling edge publishes the staged results |
| loadStb | input | 1 | One-cycle pulse capturing `resIn` into staging |
| resIn | input | 144 | Eight 18-bit results, channel 1 in the lowest bits |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| busData | output | 16 | Presented word, 0 while released |
| busOe | output | 1 | Bus driven flag (models the tri-state enable) |
| firstData | output | 1 | High while channel 1 upper word is driven |

## Verification
The hardest condition to reach is a read that overlaps a conversion. A new result set must already sit in staging and `busy` must still be high, with the host part-way through the previous set. Only then can a read expose staged data leaking early or the word pointer being disturbed. The stimulus runs conversions that issue a random number of reads between the load pulse and the fall of `busy`. It also drives `resIn` with unrelated values after the pulse. Random mixes of the three strobe styles are combined with stray read-while-deselected cycles. Reads that run past the 16th word check the wrap and the sequence position.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic loadOut;   // publish staged results (busy fell)
    logic present;   // put the selected word on the bus register
  } rdStb_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busy,
  input  logic             csN,
  input  logic             rdN,
  output rdStb_t           stb,
  output logic [PTR_W-1:0] wordSel,
  output logic             busOe
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

  logic busyQ;
  logic actNow;
  logic actQ;
  logic [PTR_W-1:0] ptrQ;

  assign actNow = !csN && !rdN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      actQ  <= 1'b0;
    end else begin
      busyQ <= busy;
      actQ  <= actNow;
    end
  end

  always_comb begin
    stb.loadOut = busyQ && !busy;
    stb.present = actNow && !actQ;
  end

  // Word pointer: reset on publish, otherwise step per strobe with wrap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (stb.loadOut) begin
      ptrQ <= '0;
    end else if (stb.present) begin
      ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
    end
  end

  assign wordSel = ptrQ;
  assign busOe   = actQ;

  p_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |=> !busOe);

  p_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN) |=> busOe);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.present && !stb.loadOut) |=> $stable(wordSel));

  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.present && !stb.loadOut && wordSel != LAST) |=>
      wordSel == $past(wordSel) + 1'b1);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.present && !stb.loadOut && wordSel == LAST) |=> wordSel == '0);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !busy) |=> wordSel == '0);

endmodule

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 18,
  parameter int BUS_W  = 16,
  localparam int WORDS = 2 * NUM_CH,
  localparam int PTR_W = $clog2(WORDS),
  localparam int LSB_W = RES_W - BUS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadStb,
  input  logic [NUM_CH*RES_W-1:0] resIn,
  input  rdStb_t                  stb,
  input  logic [PTR_W-1:0]        wordSel,
  output logic [BUS_W-1:0]        dataQ,
  output logic                    firstQ
);

  logic [RES_W-1:0] stageReg [NUM_CH];
  logic [RES_W-1:0] outReg   [NUM_CH];
  logic [BUS_W-1:0] wordArr  [WORDS];
  logic             halfQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageReg[ch] <= '0;
        outReg[ch]   <= '0;
      end else begin
        if (loadStb)     stageReg[ch] <= resIn[ch*RES_W +: RES_W];
        if (stb.loadOut) outReg[ch]   <= stageReg[ch];
      end
    end

    assign wordArr[2*ch]     = outReg[ch][RES_W-1:LSB_W];
    assign wordArr[2*ch + 1] = {{(BUS_W-LSB_W){1'b0}}, outReg[ch][LSB_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      firstQ <= 1'b0;
      halfQ  <= 1'b0;
    end else if (stb.present) begin
      dataQ  <= wordArr[wordSel];
      firstQ <= (wordSel == '0);
      halfQ  <= wordSel[0];
    end
  end

  p_lsb_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.present && wordSel[0]) |=> dataQ[BUS_W-1:LSB_W] == '0);

  p_first_upper_r9: assert property (@(posedge clk) disable iff (!rstN)
    firstQ |-> !halfQ);

  p_stage_hidden_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> $stable(outReg[0]));

endmodule

// File: rtl/adc_par_readout.sv
module adc_par_readout
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 18,
  parameter int BUS_W  = 16,
  localparam int WORDS = 2 * NUM_CH,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busy,
  input  logic                    loadStb,
  input  logic [NUM_CH*RES_W-1:0] resIn,
  input  logic                    csN,
  input  logic                    rdN,
  output logic [BUS_W-1:0]        busData,
  output logic                    busOe,
  output logic                    firstData
);

  rdStb_t           stb;
  logic [PTR_W-1:0] wordSel;
  logic [BUS_W-1:0] dataQ;
  logic             firstQ;

  adc_rd_ctrl #(.WORDS(WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .busy(busy), .csN(csN), .rdN(rdN),
    .stb(stb), .wordSel(wordSel), .busOe(busOe)
  );

  adc_rd_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .resIn(resIn),
    .stb(stb), .wordSel(wordSel), .dataQ(dataQ), .firstQ(firstQ)
  );

  assign busData   = busOe ? dataQ : '0;
  assign firstData = busOe && firstQ;

  p_first_needs_oe_r9: assert property (@(posedge clk) disable iff (!rstN)
    firstData |-> busOe);

endmodule

// File: tb/adc_par_readout_tb.sv
`timescale 1ns/1ps
module adc_par_readout_tb_top;

  localparam int NUM_CH = 8;
  localparam int RES_W  = 18;
  localparam int BUS_W  = 16;
  localparam int WORDS  = 2 * NUM_CH;

  logic clk = 1'b0;
  logic rstN, busy, loadStb, csN, rdN;
  logic [NUM_CH*RES_W-1:0] resIn;
  logic [BUS_W-1:0] busData;
  logic busOe, firstData;

  always #2.5 clk = ~clk;

  adc_par_readout dut_i (
    .clk(clk), .rstN(rstN), .busy(busy), .loadStb(loadStb), .resIn(resIn),
    .csN(csN), .rdN(rdN), .busData(busData), .busOe(busOe),
    .firstData(firstData)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [RES_W-1:0] stageM [NUM_CH];
  logic [RES_W-1:0] outM   [NUM_CH];
  int ptrM;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] expWord(input int p);
    int ch = p / 2;
    if (p % 2 == 0) return outM[ch][RES_W-1:RES_W-BUS_W];
    return {{(BUS_W-(RES_W-BUS_W)){1'b0}}, outM[ch][RES_W-BUS_W-1:0]};
  endfunction

  function automatic logic [NUM_CH*RES_W-1:0] randRes();
    logic [NUM_CH*RES_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++) v[c*RES_W +: RES_W] = RES_W'($urandom());
    return v;
  endfunction

  // One word read; mode 0 tied, 1 cs held low, 2 rd held low (R10).
  task automatic doRead(input int mode);
    logic [BUS_W-1:0] e;
    e = expWord(ptrM);
    if (mode == 2) begin rdN = 1'b0; csN = 1'b0; end
    else begin csN = 1'b0; rdN = 1'b0; end
    @(negedge clk);
    check(busOe === 1'b1, "R1 oe on read", 32'(busOe), 1);
    check(busData === e, (ptrM % 2 == 0) ? "R3 upper word" : "R4 lsb word",
          32'(busData), 32'(e));
    check(firstData === (ptrM == 0), "R9 first flag", 32'(firstData),
          32'(ptrM == 0));
    if (mode == 0) begin csN = 1'b1; rdN = 1'b1; end
    else if (mode == 1) rdN = 1'b1;
    else csN = 1'b1;
    @(negedge clk);
    check(busOe === 1'b0 && busData === '0, "R1 released",
          32'(busData), 0);
    check(firstData === 1'b0, "R9 flag low released", 32'(firstData), 0);
    ptrM = (ptrM + 1) % WORDS;
  endtask

  task automatic idleBus();
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic strayRead();
    csN = 1'b1; rdN = 1'b0;
    repeat (2) @(negedge clk);
    check(busOe === 1'b0 && busData === '0, "R2 rd without cs",
          32'(busData), 0);
    rdN = 1'b1;
    @(negedge clk);
  endtask

  // Conversion with reads overlapping busy (R7), then publish (R8).
  task automatic doConvert(input int readsDuring);
    logic [NUM_CH*RES_W-1:0] v;
    idleBus();
    busy = 1'b1;
    @(negedge clk);
    v = randRes();
    resIn = v;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    resIn = randRes();
    for (int c = 0; c < NUM_CH; c++) stageM[c] = v[c*RES_W +: RES_W];
    for (int i = 0; i < readsDuring; i++) doRead(int'($urandom_range(0, 2)));
    idleBus();
    busy = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) outM[c] = stageM[c];
    ptrM = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; busy = 1'b0; loadStb = 1'b0; csN = 1'b1; rdN = 1'b1;
    resIn = '0;
    for (int c = 0; c < NUM_CH; c++) begin stageM[c] = '0; outM[c] = '0; end
    ptrM = 0;
    repeat (3) @(negedge clk);
    check(busOe === 1'b0 && busData === '0 && firstData === 1'b0,
          "R1 reset state", {busData, 14'b0, busOe, firstData}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: full readout in tied mode, then wrap (R5, R6).
    doConvert(0);
    for (int i = 0; i < WORDS; i++) doRead(0);
    check(ptrM == 0, "R5 sixteen words consumed", 32'(ptrM), 0);
    doRead(0);
    doRead(1);

    // Directed: stray read without select, no advance (R2).
    strayRead();
    doRead(2);

    // Directed: held strobe does not advance (R2).
    csN = 1'b0; rdN = 1'b0;
    repeat (4) @(negedge clk);
    check(busData === expWord(ptrM), "R2 held strobe single word",
          32'(busData), 32'(expWord(ptrM)));
    ptrM = (ptrM + 1) % WORDS;
    idleBus();
    doRead(0);

    // Directed: reads overlapping busy read the old set (R7), then reset (R8).
    doConvert(5);
    doRead(1);

    // Directed: LSB corner values (R4).
    idleBus();
    busy = 1'b1;
    @(negedge clk);
    resIn = '1;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    for (int c = 0; c < NUM_CH; c++) stageM[c] = '1;
    busy = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) outM[c] = stageM[c];
    ptrM = 0;
    for (int i = 0; i < WORDS; i++) doRead(int'($urandom_range(0, 2)));

    // Random conversions with mixed styles, overlap and strays (R10).
    for (int n = 0; n < 40; n++) begin
      doConvert(int'($urandom_range(0, 20)));
      for (int i = 0; i < int'($urandom_range(1, 20)); i++) begin
        if ($urandom_range(0, 7) == 0) strayRead();
        doRead(int'($urandom_range(0, 2)));
      end
    end
    idleBus();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule